// File: doc/BRIEF.md
# Cell-Aligned Frame Builder with Trailer CRC-32

This block turns a stream of payload bytes into a convergence-sublayer frame that fills a whole number of 48-byte cells. Payload bytes arrive one per clock with a valid flag and a last flag. They pass straight through to the output byte stream while a CRC-32 engine folds them in. After the final payload byte the block emits zero pad bytes. It then emits an 8-byte trailer: a per-frame user byte, a per-frame common-part indicator byte, a 16-bit payload length and the complemented CRC. The output handshake is valid/ready with an end-of-frame flag. No new payload is taken while the pad or the trailer is being sent.

A check mode, selected by a level input that stays constant for a whole frame, turns the block into a receiver. It consumes a complete frame, trailer included, with no output traffic. One cycle after the final byte it pulses a done flag together with an error flag. The error flag is set when the CRC register does not end on the fixed good-frame residue.

Top module: `aal5_frame_crc`

## Requirements
- R1: The CRC register starts at 0xFFFFFFFF for every frame. Each byte is processed bit 7 first: the data bit is XORed with register bit 31, the register shifts toward bit 31 with a zero entering bit 0, and when that XOR is 1 the register is XORed with 0x04C11DB7.
- R2: In build mode (check_mode = 0), each payload byte appears on out_data unchanged and in arrival order, with out_valid = in_valid and in_ready = out_ready.
- R3: After the payload come zero bytes, just enough that the payload, the pad and the 8 trailer bytes add up to a multiple of 48. There is no pad when the payload length mod 48 is 40, and there are 47 pad bytes when it is 41.
- R4: The trailer order is user byte, indicator byte, length high byte, length low byte, then CRC bytes 31:24, 23:16, 15:8, 7:0. The user and indicator bytes are captured with the final payload byte.
- R5: The 16-bit length field equals the number of payload bytes and does not count pad or trailer bytes.
- R6: The CRC covers the payload, the pad, the user and indicator bytes and the length field. The sent CRC is the bitwise complement of the register. A 40-byte zero payload gives 0x864D7F99, a 40-byte 0xFF payload gives 0xC55E457A, bytes 0x01..0x28 give 0xBF671ED0, and the same bytes with user 0x11 and indicator 0x22 give 0xACBA602A.
- R7: out_last is high only together with out_valid on the final trailer byte.
- R8: In build mode, in_ready stays low from the cycle after the final payload byte is accepted until the final trailer byte has been taken.
- R9: While out_valid is high and out_ready is low, out_valid and out_data keep their values into the next cycle.
- R10: In check mode, in_ready is 1 and out_valid is 0. One cycle after the final byte is accepted, chk_done pulses high. crc_error is high on that pulse exactly when the register after the whole frame, CRC field included, differs from 0xC704DD7B.
- R11: While reset is held, out_valid, chk_done and crc_error are 0 and in_ready follows out_ready.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| check_mode | input | 1 | 0 builds frames, 1 checks received frames |
| in_valid | input | 1 | Input byte valid |
| in_data | input | 8 | Input byte |
| in_last | input | 1 | Input byte is the last of its frame |
| in_ready | output | 1 | Input byte accepted when high with in_valid |
| uu_in | input | 8 | Per-frame user byte, captured with the last payload byte |
| cpi_in | input | 8 | Per-frame indicator byte, captured with the last payload byte |
| out_valid | output | 1 | Output byte valid |
| out_data | output | 8 | Output byte |
| out_last | output | 1 | Final trailer byte of the frame |
| out_ready | input | 1 | Downstream accepts the output byte |
| chk_done | output | 1 | Check mode: one-cycle pulse after a frame ends |
| crc_error | output | 1 | Check mode: residue mismatch, valid with chk_done |

## Verification
The bench builds the block with its default parameters: 48-byte cells, a 16-bit length and the 8-byte trailer. These defaults make the four published trailer CRC values directly comparable. Payload lengths of 1, 40, 41 and 88 cover the largest pads (39 and 47), the zero-pad case, and frames that span two cells. The bench stalls the output handshake and changes the user and indicator inputs after capture, which exercises the hold and capture rules. Check-mode runs feed back whole frames, one of them corrupted, to drive the residue comparison both ways.

// File: rtl/aal5_pkg.sv
// Package: shared constants and state type for the cell-aligned frame builder.
// Assumes a 32-bit CRC, processed most significant bit first.
package aal5_pkg;
    localparam logic [31:0] CRC_POLY    = 32'h04C1_1DB7;
    localparam logic [31:0] CRC_INIT    = 32'hFFFF_FFFF;
    localparam logic [31:0] CRC_RESIDUE = 32'hC704_DD7B;

    typedef enum logic [1:0] {
        ST_DATA  = 2'd0,
        ST_PAD   = 2'd1,
        ST_TRAIL = 2'd2
    } frm_state_e;
endpackage

// File: rtl/aal5_crc_step.sv
// Module: combinational CRC-32 advance by DATA_W bits, MSB of data first.
// Assumes the register shifts toward bit 31 and the caller registers the result.
module aal5_crc_step #(
    parameter int          DATA_W = 8,
    parameter logic [31:0] POLY   = aal5_pkg::CRC_POLY
) (
    input  logic [31:0]       crc_in,
    input  logic [DATA_W-1:0] data_in,
    output logic [31:0]       crc_out
);
    logic [31:0] acc;

    // Fold the data bits one at a time, earliest (highest) bit first.
    always_comb begin
        acc = crc_in;
        for (int i = DATA_W - 1; i >= 0; i--) begin
            if (acc[31] ^ data_in[i])
                acc = {acc[30:0], 1'b0} ^ POLY;
            else
                acc = {acc[30:0], 1'b0};
        end
        crc_out = acc;
    end
endmodule

// File: rtl/aal5_cell_pos.sv
// Module: tracks the payload position within a cell and works out the pad.
// Assumes TRAIL_BYTES <= CELL_BYTES; pad_after is valid for a byte being
// accepted now, as if it were the last one of the frame.
module aal5_cell_pos #(
    parameter int CELL_BYTES  = 48,
    parameter int TRAIL_BYTES = 8,
    localparam int POS_W      = $clog2(CELL_BYTES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bump,
    input  logic             clear,
    output logic [POS_W-1:0] pad_after
);
    localparam int HEAD = CELL_BYTES - TRAIL_BYTES;

    logic [POS_W-1:0] pos_q;
    logic [POS_W-1:0] pos_nx;

    // Position after the byte now being accepted, wrapping at a cell.
    always_comb begin
        pos_nx = (pos_q == POS_W'(CELL_BYTES - 1)) ? '0 : pos_q + 1'b1;
    end

    // Pad length that brings the payload plus trailer to a cell boundary.
    always_comb begin
        if (int'(pos_nx) <= HEAD)
            pad_after = POS_W'(HEAD - int'(pos_nx));
        else
            pad_after = POS_W'(HEAD + CELL_BYTES - int'(pos_nx));
    end

    // Count payload bytes modulo the cell size; reset at each frame end.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) pos_q <= '0;
        else if (bump)       pos_q <= pos_nx;
    end

    // R3
    pad_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        int'(pad_after) < CELL_BYTES);
endmodule

// File: rtl/aal5_trailer_mux.sv
// Module: selects the trailer byte for a given trailer index.
// Assumes the index stays below the trailer size; CRC bytes are sent complemented.
module aal5_trailer_mux #(
    parameter int LEN_W        = 16,
    localparam int TRAIL_BYTES = 2 + LEN_W / 8 + 4,
    localparam int IDX_W       = $clog2(TRAIL_BYTES)
) (
    input  logic [IDX_W-1:0] idx,
    input  logic [7:0]       uu,
    input  logic [7:0]       cpi,
    input  logic [LEN_W-1:0] len,
    input  logic [31:0]      crc,
    output logic [7:0]       byte_out,
    output logic             covered
);
    logic [TRAIL_BYTES*8-1:0] fields;

    // Pack the trailer in send order, first byte in the top bits.
    always_comb begin
        fields = {uu, cpi, len, ~crc};
    end

    // Pick one byte; bytes before the CRC are covered by the CRC.
    always_comb begin
        byte_out = fields[(TRAIL_BYTES - 1 - int'(idx)) * 8 +: 8];
        covered  = int'(idx) < TRAIL_BYTES - 4;
    end
endmodule

// File: rtl/aal5_frame_crc.sv
// Module: builds cell-aligned frames with pad and trailer CRC, or checks
// received frames against the CRC residue. Payload passes through with no
// buffering. Assumes check_mode is constant within a frame and that the
// source holds in_valid and in_data while in_ready is low.
module aal5_frame_crc #(
    parameter int CELL_BYTES = 48,
    parameter int LEN_W      = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       check_mode,
    input  logic       in_valid,
    input  logic [7:0] in_data,
    input  logic       in_last,
    output logic       in_ready,
    input  logic [7:0] uu_in,
    input  logic [7:0] cpi_in,
    output logic       out_valid,
    output logic [7:0] out_data,
    output logic       out_last,
    input  logic       out_ready,
    output logic       chk_done,
    output logic       crc_error
);
    import aal5_pkg::*;

    localparam int TRAIL_BYTES = 2 + LEN_W / 8 + 4;
    localparam int IDX_W       = $clog2(TRAIL_BYTES);
    localparam int POS_W       = $clog2(CELL_BYTES);

    frm_state_e       state_q;
    logic [31:0]      crc_q;
    logic [31:0]      crc_nx;
    logic [LEN_W-1:0] len_q;
    logic [7:0]       uu_q;
    logic [7:0]       cpi_q;
    logic [POS_W-1:0] pad_q;
    logic [POS_W-1:0] pad_after;
    logic [IDX_W-1:0] tidx_q;
    logic [7:0]       trl_byte;
    logic             trl_cov;
    logic [7:0]       step_byte;
    logic             take_in;
    logic             fire_out;
    logic             chk_done_q;
    logic             crc_err_q;

    // Handshake and data routing per state.
    always_comb begin
        in_ready  = 1'b0;
        out_valid = 1'b0;
        out_data  = 8'h00;
        out_last  = 1'b0;
        case (state_q)
            ST_DATA: begin
                if (check_mode) begin
                    in_ready = 1'b1;
                end else begin
                    in_ready  = out_ready;
                    out_valid = in_valid;
                    out_data  = in_data;
                end
            end
            ST_PAD: begin
                out_valid = 1'b1;
            end
            ST_TRAIL: begin
                out_valid = 1'b1;
                out_data  = trl_byte;
                out_last  = (tidx_q == IDX_W'(TRAIL_BYTES - 1));
            end
            default: ;
        endcase
    end

    // Transfer strobes and the byte fed to the CRC engine.
    always_comb begin
        take_in   = in_valid && in_ready;
        fire_out  = out_valid && out_ready;
        step_byte = (state_q == ST_DATA) ? in_data : out_data;
    end

    aal5_crc_step #(.DATA_W(8), .POLY(CRC_POLY)) u_step (
        .crc_in  (crc_q),
        .data_in (step_byte),
        .crc_out (crc_nx)
    );

    aal5_cell_pos #(.CELL_BYTES(CELL_BYTES), .TRAIL_BYTES(TRAIL_BYTES)) u_pos (
        .clk       (clk),
        .rst_n     (rst_n),
        .bump      (state_q == ST_DATA && take_in && !in_last),
        .clear     (state_q == ST_DATA && take_in && in_last),
        .pad_after (pad_after)
    );

    aal5_trailer_mux #(.LEN_W(LEN_W)) u_trl (
        .idx      (tidx_q),
        .uu       (uu_q),
        .cpi      (cpi_q),
        .len      (len_q),
        .crc      (crc_q),
        .byte_out (trl_byte),
        .covered  (trl_cov)
    );

    // Frame sequencer: payload, pad, trailer, and CRC bookkeeping.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= ST_DATA;
            crc_q      <= CRC_INIT;
            len_q      <= '0;
            uu_q       <= '0;
            cpi_q      <= '0;
            pad_q      <= '0;
            tidx_q     <= '0;
            chk_done_q <= 1'b0;
            crc_err_q  <= 1'b0;
        end else begin
            chk_done_q <= 1'b0;
            crc_err_q  <= 1'b0;
            case (state_q)
                ST_DATA: begin
                    if (take_in) begin
                        if (!in_last) begin
                            crc_q <= crc_nx;
                            len_q <= len_q + 1'b1;
                        end else if (check_mode) begin
                            chk_done_q <= 1'b1;
                            crc_err_q  <= (crc_nx != CRC_RESIDUE);
                            crc_q      <= CRC_INIT;
                            len_q      <= '0;
                        end else begin
                            crc_q   <= crc_nx;
                            len_q   <= len_q + 1'b1;
                            uu_q    <= uu_in;
                            cpi_q   <= cpi_in;
                            pad_q   <= pad_after;
                            tidx_q  <= '0;
                            state_q <= (pad_after == '0) ? ST_TRAIL : ST_PAD;
                        end
                    end
                end
                ST_PAD: begin
                    if (fire_out) begin
                        crc_q <= crc_nx;
                        pad_q <= pad_q - 1'b1;
                        if (pad_q == POS_W'(1)) state_q <= ST_TRAIL;
                    end
                end
                ST_TRAIL: begin
                    if (fire_out) begin
                        if (trl_cov) crc_q <= crc_nx;
                        tidx_q <= tidx_q + 1'b1;
                        if (out_last) begin
                            state_q <= ST_DATA;
                            crc_q   <= CRC_INIT;
                            len_q   <= '0;
                        end
                    end
                end
                default: state_q <= ST_DATA;
            endcase
        end
    end

    // Drive the check-mode result ports from their registers.
    always_comb begin
        chk_done  = chk_done_q;
        crc_error = crc_err_q;
    end

    // R9
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_data));

    // R8
    in_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && in_ready && in_last && !check_mode |=> !in_ready);

    // R7
    last_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_last |-> out_valid);

    // R10
    chk_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        state_q == ST_DATA && check_mode |-> !out_valid);

    // R10
    done_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        chk_done |-> $past(in_valid && in_ready && in_last && check_mode));

    // R10
    err_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        crc_error |-> chk_done);
endmodule

// File: tb/aal5_frame_crc_test.sv
module aal5_frame_crc_test;
    localparam int CLK_P = 10;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       check_mode;
    logic       in_valid;
    logic [7:0] in_data;
    logic       in_last;
    logic       in_ready;
    logic [7:0] uu_in;
    logic [7:0] cpi_in;
    logic       out_valid;
    logic [7:0] out_data;
    logic       out_last;
    logic       out_ready;
    logic       chk_done;
    logic       crc_error;

    int checks = 0;
    int errors = 0;

    logic [7:0] exp_b [0:255];
    int         exp_n;
    int         exp_pad;
    logic [7:0] cap_b [0:255];
    int         cap_n;

    always #(CLK_P/2) clk = ~clk;

    aal5_frame_crc uut (
        .clk(clk), .rst_n(rst_n), .check_mode(check_mode),
        .in_valid(in_valid), .in_data(in_data), .in_last(in_last), .in_ready(in_ready),
        .uu_in(uu_in), .cpi_in(cpi_in),
        .out_valid(out_valid), .out_data(out_data), .out_last(out_last), .out_ready(out_ready),
        .chk_done(chk_done), .crc_error(crc_error)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // Reference CRC advance by one byte, bit 7 first (R1).
    function automatic logic [31:0] ref_step(input logic [31:0] c, input logic [7:0] b);
        logic [31:0] r = c;
        for (int k = 7; k >= 0; k--) begin
            if (r[31] ^ b[k]) r = {r[30:0], 1'b0} ^ 32'h04C11DB7;
            else              r = {r[30:0], 1'b0};
        end
        return r;
    endfunction

    function automatic logic [7:0] pat(input int kind, input int i);
        if (kind == 0) return 8'h00;
        if (kind == 1) return 8'hFF;
        return 8'(i + 1);
    endfunction

    // Build the expected frame: payload, zero pad, trailer.
    task automatic build(input int n, input int kind, input logic [7:0] uu, input logic [7:0] cpi);
        logic [31:0] c = 32'hFFFFFFFF;
        exp_pad = (48 - ((n + 8) % 48)) % 48;
        exp_n = 0;
        for (int i = 0; i < n; i++) begin exp_b[exp_n] = pat(kind, i); exp_n++; end
        for (int i = 0; i < exp_pad; i++) begin exp_b[exp_n] = 8'h00; exp_n++; end
        exp_b[exp_n] = uu;       exp_n++;
        exp_b[exp_n] = cpi;      exp_n++;
        exp_b[exp_n] = 8'(n >> 8); exp_n++;
        exp_b[exp_n] = 8'(n);    exp_n++;
        for (int i = 0; i < exp_n; i++) c = ref_step(c, exp_b[i]);
        c = ~c;
        for (int i = 3; i >= 0; i--) begin exp_b[exp_n] = c[i*8 +: 8]; exp_n++; end
    endtask

    task automatic run_gen(input string tag, input int n, input int kind,
                           input logic [7:0] uu, input logic [7:0] cpi, input bit stall,
                           input bit use_lit, input logic [31:0] lit);
        int i = 0; int cyc = 0; bit done = 0; bit last_taken = 0; bit prev_stall = 0;
        logic [7:0] prev_d = 8'h00;
        int hold_bad = 0; int rdy_bad = 0; int last_bad = 0;
        int bad_pay = 0; int bad_pad = 0; int bad_trl = 0;
        logic [31:0] crc_w; logic [15:0] len_w;
        build(n, kind, uu, cpi);
        cap_n = 0;
        while (!done && cyc < 2000) begin
            @(negedge clk);
            check_mode = 1'b0;
            in_valid   = (i < n);
            in_data    = (i < n) ? pat(kind, i) : 8'h00;
            in_last    = (i == n - 1);
            uu_in      = last_taken ? ~uu : uu;
            cpi_in     = last_taken ? ~cpi : cpi;
            out_ready  = stall ? (cyc % 3 != 1) : 1'b1;
            #(CLK_P/2 - 1);
            if (prev_stall && !(out_valid && out_data == prev_d)) hold_bad++;
            if (last_taken && in_ready) rdy_bad++;
            if (in_valid && in_ready) begin
                if (in_last) last_taken = 1;
                i++;
            end
            if (out_valid && out_ready) begin
                if (cap_n < 256) cap_b[cap_n] = out_data;
                if (out_last) begin
                    done = 1;
                    if (cap_n != exp_n - 1) last_bad++;
                end
                cap_n++;
            end
            prev_stall = out_valid && !out_ready;
            prev_d = out_data;
            cyc++;
        end
        in_valid = 1'b0;
        in_last  = 1'b0;
        check(done == 1, "R7", {tag, " out_last seen"}, 32'(done), 32'd1);
        check(last_bad == 0, "R7", {tag, " out_last position"}, 32'(last_bad), 32'd0);
        check(cap_n == exp_n, "R3", {tag, " frame length"}, 32'(cap_n), 32'(exp_n));
        for (int k = 0; k < exp_n && k < cap_n; k++) begin
            if (cap_b[k] != exp_b[k]) begin
                if (k < n) bad_pay++;
                else if (k < n + exp_pad) bad_pad++;
                else bad_trl++;
            end
        end
        check(bad_pay == 0, "R2", {tag, " payload bytes"}, 32'(bad_pay), 32'd0);
        check(bad_pad == 0, "R3", {tag, " pad bytes"}, 32'(bad_pad), 32'd0);
        check(bad_trl == 0, "R4", {tag, " trailer bytes"}, 32'(bad_trl), 32'd0);
        if (cap_n == exp_n) begin
            len_w = {cap_b[exp_n-6], cap_b[exp_n-5]};
            check(len_w == 16'(n), "R5", {tag, " length field"}, 32'(len_w), 32'(n));
            crc_w = {cap_b[exp_n-4], cap_b[exp_n-3], cap_b[exp_n-2], cap_b[exp_n-1]};
            if (use_lit)
                check(crc_w == lit, "R6", {tag, " known CRC"}, crc_w, lit);
        end
        check(rdy_bad == 0, "R8", {tag, " in_ready low during pad/trailer"}, 32'(rdy_bad), 32'd0);
        if (stall)
            check(hold_bad == 0, "R9", {tag, " hold under stall"}, 32'(hold_bad), 32'd0);
    endtask

    task automatic run_chk(input string tag, input int n, input int kind,
                           input logic [7:0] uu, input logic [7:0] cpi,
                           input int flip, input bit exp_err);
        int i = 0; int cyc = 0; int ov_bad = 0; int rdy_bad = 0; int early = 0;
        build(n, kind, uu, cpi);
        if (flip >= 0) exp_b[flip] = exp_b[flip] ^ 8'h10;
        while (i < exp_n && cyc < 2000) begin
            @(negedge clk);
            check_mode = 1'b1;
            in_valid   = 1'b1;
            in_data    = exp_b[i];
            in_last    = (i == exp_n - 1);
            out_ready  = 1'b1;
            #(CLK_P/2 - 1);
            if (out_valid) ov_bad++;
            if (!in_ready) rdy_bad++;
            if (chk_done) early++;
            if (in_valid && in_ready) i++;
            cyc++;
        end
        @(negedge clk);
        in_valid = 1'b0;
        in_last  = 1'b0;
        #(CLK_P/2 - 1);
        check(chk_done == 1'b1, "R10", {tag, " chk_done pulse"}, 32'(chk_done), 32'd1);
        check(crc_error == exp_err, "R10", {tag, " crc_error"}, 32'(crc_error), 32'(exp_err));
        check(ov_bad == 0 && rdy_bad == 0 && early == 0, "R10", {tag, " quiet consume"},
              32'(ov_bad + rdy_bad + early), 32'd0);
        @(negedge clk);
        check_mode = 1'b0;
        #(CLK_P/2 - 1);
        check(chk_done == 1'b0, "R10", {tag, " pulse ends"}, 32'(chk_done), 32'd0);
    endtask

    initial begin
        #(CLK_P * 100000);
        errors++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        rst_n = 1'b0; check_mode = 1'b0; in_valid = 1'b0; in_data = 8'h00; in_last = 1'b0;
        uu_in = 8'h00; cpi_in = 8'h00; out_ready = 1'b1;
        repeat (3) @(negedge clk);
        #(CLK_P/2 - 1);
        // R11: reset state
        check(out_valid == 0 && chk_done == 0 && crc_error == 0 && in_ready == 1, "R11",
              "reset outputs", {28'd0, out_valid, chk_done, crc_error, in_ready}, 32'h1);
        @(negedge clk);
        rst_n = 1'b1;

        run_gen("zeros40", 40, 0, 8'h00, 8'h00, 0, 1, 32'h864D7F99);
        run_gen("ones40", 40, 1, 8'h00, 8'h00, 1, 1, 32'hC55E457A);
        // R1: CRC restarts from all ones after earlier frames
        run_gen("count40", 40, 2, 8'h00, 8'h00, 0, 1, 32'hBF671ED0);
        run_gen("count40uu", 40, 2, 8'h11, 8'h22, 1, 1, 32'hACBA602A);
        run_gen("len1", 1, 2, 8'h5A, 8'hA5, 1, 0, 32'h0);
        run_gen("len41", 41, 2, 8'h01, 8'h02, 0, 0, 32'h0);
        run_gen("len88", 88, 1, 8'h33, 8'h44, 1, 0, 32'h0);

        run_chk("chk_good", 40, 0, 8'h00, 8'h00, -1, 1'b0);
        run_chk("chk_bad", 41, 2, 8'h11, 8'h22, 5, 1'b1);
        run_chk("chk_good1", 1, 1, 8'h07, 8'h09, -1, 1'b0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule